// File: doc/BRIEF.md
# Dual-Mode Sample Demultiplexer with Divider

This block sits behind an 8-bit conversion core. It delivers each captured sample on one of two registered output ports, called port A and port B. In paired mode the block splits the sample stream at half rate. Two consecutive samples form a pair. The first sample of a pair lands on port A and the second on port B, and both ports change on the same edge. A divide-by-two clock is driven out with the data, so that a downstream latch can capture both ports.

In direct mode every sample goes to port B at the full input rate. The clock output is then the inverted input clock.

A synchronous active-low reset fixes the phase of the divider. Several instances that release reset on the same edge therefore produce identical half-rate clocks. A polarity input can invert the data. The mode input may change only while reset is held low.

Top module: `smp_demux`

## Requirements
- R1: `demuxSel` = 1 selects paired mode and `demuxSel` = 0 selects direct mode. The mode may only change while `rstN` is low.
- R2: In paired mode, `clkOut` toggles at every rising edge of `clk` at which `rstN` is high, so its frequency is half that of `clk`.
- R3: In paired mode, the first sample captured after reset release goes to port A and the next one to port B. Both ports update together at the edge that captures the port-B sample, which is the edge at which `clkOut` falls. Later pairs follow the same pattern.
- R4: In direct mode, port B takes the sample captured at every rising edge, with one register of latency. Port A keeps its value.
- R5: At every rising edge where `rstN` is low, `clkOut` (in paired mode) and both ports are driven to 0, whatever the divider phase was before.
- R6: The reset period lasts as many edges as `rstN` is seen low. The first edge at which `rstN` is seen high again drives `clkOut` high.
- R7: When `polKeep` is 0 at the capturing edge, all 8 bits of that sample are inverted. When it is 1, the sample passes unchanged. Board-level tie-off should hold it high when unused.
- R8: In direct mode, `clkOut` is the logical inverse of `clk`: it is 0 while `clk` is high and 1 while `clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset; aligns the divider phase |
| demuxSel | input | 1 | 1 = paired half-rate mode, 0 = direct full-rate mode |
| polKeep | input | 1 | 1 = data unchanged, 0 = all data bits inverted |
| sampleIn | input | 8 | Sample word from the conversion core |
| portA | output | 8 | First port; carries the first sample of each pair |
| portB | output | 8 | Second port; carries the second sample of a pair, or every sample in direct mode |
| clkOut | output | 1 | Half-rate clock in paired mode, inverted `clk` in direct mode |

## Verification
The bench releases reset and tracks which port receives the first sample. A design that started with port B, or whose divider started in the wrong phase, would swap or delay every pair. It asserts reset while `clkOut` is high and holds it for two edges. This catches a divider that waits for its own low phase, or that restarts with `clkOut` low. The polarity level is changed within a pair, so that a design which inverts at the port instead of at capture shows a mismatch. In direct mode the bench checks `clkOut` on both clock phases and confirms that port A stays untouched.

// File: rtl/smp_demux_pkg.sv
package smp_demux_pkg;

  // Strobes issued by the control to the datapath, one cycle's worth each.
  typedef struct packed {
    logic clearAll;     // reset seen at this edge
    logic captureHold;  // park the first sample of a pair
    logic writePair;    // load both ports together
    logic writeDirect;  // load port B with the current sample
  } steer_t;

endpackage

// File: rtl/smp_demux_ctrl.sv
module smp_demux_ctrl
  import smp_demux_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   demuxSel,
  output steer_t steer,
  output logic   clkOut
);

  logic divQ;

  // Divider phase: 0 = waiting for first sample of a pair, 1 = second sample.
  always_ff @(posedge clk) begin
    if (!rstN)         divQ <= 1'b0;
    else if (demuxSel) divQ <= ~divQ;
    else               divQ <= 1'b0;
  end

  always_comb begin
    steer             = '0;
    steer.clearAll    = !rstN;
    steer.captureHold = rstN && demuxSel && !divQ;
    steer.writePair   = rstN && demuxSel &&  divQ;
    steer.writeDirect = rstN && !demuxSel;
  end

  assign clkOut = demuxSel ? divQ : ~clk;

  // R2: in paired mode the divider flips at every edge out of reset
  p_div_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    demuxSel |=> (divQ != $past(divQ)));

  // R6: first edge with reset high after a reset edge raises the divided clock
  p_restart_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) == 1'b0 && demuxSel) |=> divQ);

  // R3: at most one strobe of the steering set per edge
  p_one_strobe_r3: assert property (@(posedge clk)
    $onehot0({steer.captureHold, steer.writePair, steer.writeDirect}));

endmodule

// File: rtl/smp_demux_dpath.sv
module smp_demux_dpath
  import smp_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  steer_t            steer,
  input  logic              polKeep,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] portA,
  output logic [DATA_W-1:0] portB
);

  localparam int LAST_BIT = DATA_W - 1;

  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] holdA;

  // Polarity applied per bit at capture time.
  for (genvar i = 0; i <= LAST_BIT; i++) begin : g_pol
    assign shaped[i] = sampleIn[i] ^ ~polKeep;
  end

  always_ff @(posedge clk) begin
    if (steer.clearAll) begin
      holdA <= '0;
      portA <= '0;
      portB <= '0;
    end else begin
      if (steer.captureHold) holdA <= shaped;
      if (steer.writePair) begin
        portA <= holdA;
        portB <= shaped;
      end
      if (steer.writeDirect) portB <= shaped;
    end
  end

  // R3: ports stay put on the edge that parks the first sample of a pair
  p_pair_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    steer.captureHold |=> ($stable(portA) && $stable(portB)));

  // R4: direct mode leaves port A untouched
  p_porta_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    steer.writeDirect |=> $stable(portA));

  // R5: a reset edge clears both ports
  p_clear_ports_r5: assert property (@(posedge clk)
    steer.clearAll |=> (portA == '0 && portB == '0));

endmodule

// File: rtl/smp_demux.sv
module smp_demux
  import smp_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              demuxSel,
  input  logic              polKeep,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [DATA_W-1:0] portA,
  output logic [DATA_W-1:0] portB,
  output logic              clkOut
);

  steer_t steer;

  smp_demux_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .demuxSel (demuxSel),
    .steer    (steer),
    .clkOut   (clkOut)
  );

  smp_demux_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .steer    (steer),
    .polKeep  (polKeep),
    .sampleIn (sampleIn),
    .portA    (portA),
    .portB    (portB)
  );

  // R1: mode input only moves while reset is low
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(demuxSel));

  // R5: a reset edge in paired mode leaves the clock output low
  p_clk_low_r5: assert property (@(posedge clk)
    (!rstN && demuxSel) |=> !clkOut);

endmodule

// File: tb/smp_demux_bench.sv
`timescale 1ns/1ps
module smp_demux_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       demuxSel = 1'b1;
  logic       polKeep = 1'b1;
  logic [7:0] sampleIn = 8'h00;
  logic [7:0] portA, portB;
  logic       clkOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  smp_demux u_smp_demux (
    .clk(clk), .rstN(rstN), .demuxSel(demuxSel), .polKeep(polKeep),
    .sampleIn(sampleIn), .portA(portA), .portB(portB), .clkOut(clkOut)
  );

  // {sample, polKeep, expected portA, expected portB, expected clkOut}
  localparam logic [25:0] VEC [8] = '{
    {8'h3C, 1'b1, 8'h00, 8'h00, 1'b1},
    {8'hA5, 1'b1, 8'h3C, 8'hA5, 1'b0},
    {8'h0F, 1'b0, 8'h3C, 8'hA5, 1'b1},
    {8'h81, 1'b1, 8'hF0, 8'h81, 1'b0},
    {8'hFF, 1'b0, 8'hF0, 8'h81, 1'b1},
    {8'h00, 1'b0, 8'h00, 8'hFF, 1'b0},
    {8'h5A, 1'b1, 8'h00, 8'hFF, 1'b1},
    {8'hC3, 1'b0, 8'h5A, 8'h3C, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic edgeWait();
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] vs, ea, eb;
    logic       vp, ec;

    // R5: reset state in paired mode
    rstN = 1'b0; demuxSel = 1'b1;
    repeat (3) edgeWait();
    chk("R5 clkOut in reset", {7'b0, clkOut}, 8'h00);
    chk("R5 portA in reset", portA, 8'h00);
    chk("R5 portB in reset", portB, 8'h00);

    // R1 R2 R3 R7: paired stream from the table
    for (int i = 0; i < 8; i++) begin
      {vs, vp, ea, eb, ec} = VEC[i];
      rstN = 1'b1; sampleIn = vs; polKeep = vp;
      edgeWait();
      chk($sformatf("R3 portA step %0d", i), portA, ea);
      chk($sformatf("R3/R7 portB step %0d", i), portB, eb);
      chk($sformatf("R2 clkOut step %0d", i), {7'b0, clkOut}, {7'b0, ec});
    end

    // R5 R6: reset taken while clkOut is high, held two edges
    sampleIn = 8'h77; polKeep = 1'b1;
    edgeWait();
    chk("R2 clkOut high before reset", {7'b0, clkOut}, 8'h01);
    rstN = 1'b0;
    edgeWait();
    chk("R5 clkOut forced low", {7'b0, clkOut}, 8'h00);
    edgeWait();
    chk("R6 clkOut low second reset edge", {7'b0, clkOut}, 8'h00);
    chk("R5 portA cleared", portA, 8'h00);
    rstN = 1'b1; sampleIn = 8'h11;
    edgeWait();
    chk("R6 clkOut high at first release edge", {7'b0, clkOut}, 8'h01);
    chk("R3 ports quiet on first capture", portB, 8'h00);
    sampleIn = 8'h22;
    edgeWait();
    chk("R3 first sample after release on portA", portA, 8'h11);
    chk("R3 second sample on portB", portB, 8'h22);
    chk("R2 clkOut falls with pair update", {7'b0, clkOut}, 8'h00);

    // R1 R4 R8: direct mode, entered under reset
    rstN = 1'b0; demuxSel = 1'b0;
    edgeWait();
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sampleIn = 8'h40 + 8'(k * 3);
      polKeep = (k != 2);
      edgeWait();
      chk($sformatf("R4 portB direct %0d", k), portB,
          (k == 2) ? ~(8'h40 + 8'(k * 3)) : (8'h40 + 8'(k * 3)));
      chk($sformatf("R4 portA held %0d", k), portA, 8'h00);
      chk($sformatf("R8 clkOut while clk high %0d", k), {7'b0, clkOut}, 8'h00);
      @(negedge clk); #1;
      chk($sformatf("R8 clkOut while clk low %0d", k), {7'b0, clkOut}, 8'h01);
    end

    // R7: full inversion of an all-ones word in direct mode
    sampleIn = 8'hFF; polKeep = 1'b0;
    edgeWait();
    chk("R7 all bits inverted", portB, 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule